// File: doc/BRIEF.md
# Interval Timer Bus Register Interface

This block is the byte-wide register front end of a three-channel interval timer. A processor talks to it through a 2-bit address with separate write and read strobes. Address 3 takes control words; addresses 0, 1 and 2 are the count data ports of channels 0, 1 and 2. The block keeps, for each channel, its access style (low byte, high byte or low-then-high), its counting mode and its BCD flag. It also tracks which byte comes next on reads and writes.

When a complete count has been written, the block pulses a load strobe to that channel's counter and presents the 16-bit value. On reads it returns bytes of the channel's live count. It can also return a frozen snapshot of the count, or a status byte, captured by a latch command or by a read-back command that covers several channels at once. The counters, with their arithmetic and their OUT logic, sit outside. They feed their live count and OUT back into this block.

Top module: `tmr_bus_regs`

## Requirements
- R1: After reset every channel is in low-then-high access, mode 0, binary counting, with both byte pointers on the low byte. No latch is pending, all load strobes are low and every presented count is 0.
- R2: A control word (write to address 3) with bits 7:6 below 3 and bits 5:4 non-zero configures only the channel named by bits 7:6. Its access style comes from bits 5:4 (1 low only, 2 high only, 3 low then high), its mode from bits 3:1 and its BCD flag from bit 0. The write resets that channel's read and write byte pointers to the low byte.
- R3: Mode codes 6 and 7 in a control word are stored and presented as 2 and 3.
- R4: In low-only access a data byte b loads {8'h00,b}, and in high-only access it loads {b,8'h00`}. The load strobe of that one channel is high for exactly the cycle after the write.
- R5: In low-then-high access the first data byte is held and causes no load. The second byte loads {second,first}.
- R6: A control word with bits 5:4 equal to 0 snapshots the named channel's live count. The following reads return the snapshot: low then high byte in two-byte access, or the single configured byte otherwise. Reads then return to the live count. A count latch issued while a snapshot is still unread is ignored.
- R7: A control word with bits 7:6 equal to 3 is a read-back. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 low latches the count and bit 4 low latches the status of each selected channel. Unselected channels are untouched.
- R8: The status byte is {OUT, 0, access[1:0], mode[2:0], BCD}, with OUT taken when the latch is issued.
- R9: A pending status byte is read before a pending count snapshot, and it is returned only once. A status latch issued while a status byte is still unread is ignored.
- R10: With nothing latched, reads return the live count's low byte in low-only access and its high byte in high-only access. In two-byte access reads alternate low, high, low, starting from the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register address: 0..2 channel data, 3 control |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; read state advances at the clock edge |
| rdata | output | 8 | Read data for the addressed register (combinational) |
| ch_count_i | input | 48 | Live counts of channels 2..0, 16 bits each |
| ch_out_i | input | 3 | Live OUT level of each channel |
| ld_stb | output | 3 | Per-channel load strobe, one cycle |
| ld_cnt | output | 48 | Count presented to each channel, 16 bits each |
| ch_mode | output | 9 | Mode of each channel, 3 bits each |
| ch_bcd | output | 3 | BCD flag of each channel |

## Verification
Writes are tried in all three access styles, and a control word is issued midway through a two-byte write. This shows whether the held byte is dropped and the pointer really returns to the low byte. The live count is changed between a latch command and its reads, so that snapshot data can be told apart from live data. Repeated latch commands check that a pending snapshot or status byte is not overwritten. Read-back commands use mixed channel masks with count only, status only and both. These separate the ordering of status before count, the selection of channels and the untouched state of unselected channels.

// File: rtl/tmr_regs_pkg.sv
// Shared constants, types and helpers for the timer bus register interface.
package tmr_regs_pkg;
    localparam int NUM_CH  = 3;
    localparam int CNT_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int MODE_W  = 3;
    localparam logic [1:0] CTL_ADDR = 2'd3;

    // Byte access style; ACC_NONE doubles as "no snapshot pending".
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_WORD = 2'd3
    } acc_e;

    // Map the two aliased mode codes (6, 7) onto 2 and 3.
    function automatic logic [MODE_W-1:0] fold_mode(input logic [MODE_W-1:0] m);
        return (m[2] && m[1]) ? {1'b0, m[1:0]} : m;
    endfunction
endpackage

// File: rtl/tmr_cmd_decode.sv
// Decodes one bus write into per-channel requests.
// Assumes at most one write per cycle; reads are handled elsewhere.
module tmr_cmd_decode
    import tmr_regs_pkg::*;
#(
    parameter int N_CH = NUM_CH
) (
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [N_CH-1:0]   data_wr,
    output logic [N_CH-1:0]   cfg_wr,
    output logic [N_CH-1:0]   cnt_lat_req,
    output logic [N_CH-1:0]   st_lat_req
);
    logic       is_ctl;
    logic       is_rb;
    logic [1:0] sel;
    logic       acc_zero;

    // Fields shared by all channels.
    always_comb begin
        is_ctl   = wr_en && (addr == CTL_ADDR);
        sel      = wdata[7:6];
        is_rb    = (sel == 2'd3);
        acc_zero = (wdata[5:4] == 2'b00);
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic hit;
        logic rb_pick;
        // Per-channel request decode.
        always_comb begin
            hit            = is_ctl && !is_rb && (sel == 2'(i));
            rb_pick        = is_ctl && is_rb && wdata[i+1];
            data_wr[i]     = wr_en && (addr == 2'(i));
            cfg_wr[i]      = hit && !acc_zero;
            cnt_lat_req[i] = (hit && acc_zero) || (rb_pick && !wdata[5]);
            st_lat_req[i]  = rb_pick && !wdata[4];
        end
    end
endmodule

// File: rtl/tmr_chan_regs.sv
// Register state of one timer channel: configuration, byte pointers,
// count snapshot and status snapshot. Produces the byte a read would
// return and a one-cycle load strobe with the assembled count.
// Assumes requests arrive from one bus access per cycle.
module tmr_chan_regs
    import tmr_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic              cfg_wr,
    input  logic              cnt_lat_req,
    input  logic              st_lat_req,
    input  logic              rd_stb,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic              live_out,
    output logic [BYTE_W-1:0] rbyte,
    output logic              ld_stb,
    output logic [CNT_W-1:0]  ld_cnt,
    output logic [MODE_W-1:0] mode,
    output logic              bcd
);
    acc_e              acc_q;
    acc_e              clat_st_q;
    logic [MODE_W-1:0] mode_q;
    logic              bcd_q;
    logic              wr_hi_q;
    logic              rd_hi_q;
    logic [BYTE_W-1:0] wlat_q;
    logic [CNT_W-1:0]  clat_q;
    logic              st_vld_q;
    logic [BYTE_W-1:0] st_q;
    logic              ld_stb_q;
    logic [CNT_W-1:0]  ld_cnt_q;

    // Select the byte the next read of this channel returns.
    always_comb begin
        if (st_vld_q) begin
            rbyte = st_q;
        end else if (clat_st_q == ACC_HI) begin
            rbyte = clat_q[15:8];
        end else if (clat_st_q != ACC_NONE) begin
            rbyte = clat_q[7:0];
        end else if (acc_q == ACC_HI || (acc_q == ACC_WORD && rd_hi_q)) begin
            rbyte = live_cnt[15:8];
        end else begin
            rbyte = live_cnt[7:0];
        end
    end

    // Configuration, write sequencing, latches and read sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= ACC_WORD;
            mode_q    <= '0;
            bcd_q     <= 1'b0;
            wr_hi_q   <= 1'b0;
            rd_hi_q   <= 1'b0;
            wlat_q    <= '0;
            clat_q    <= '0;
            clat_st_q <= ACC_NONE;
            st_vld_q  <= 1'b0;
            st_q      <= '0;
            ld_stb_q  <= 1'b0;
            ld_cnt_q  <= '0;
        end else begin
            ld_stb_q <= 1'b0;
            if (cfg_wr) begin
                acc_q   <= acc_e'(wdata[5:4]);
                mode_q  <= fold_mode(wdata[3:1]);
                bcd_q   <= wdata[0];
                wr_hi_q <= 1'b0;
                rd_hi_q <= 1'b0;
            end
            if (data_wr) begin
                unique case (acc_q)
                    ACC_LO: begin
                        ld_stb_q <= 1'b1;
                        ld_cnt_q <= {8'h00, wdata};
                    end
                    ACC_HI: begin
                        ld_stb_q <= 1'b1;
                        ld_cnt_q <= {wdata, 8'h00};
                    end
                    default: begin
                        if (wr_hi_q) begin
                            ld_stb_q <= 1'b1;
                            ld_cnt_q <= {wdata, wlat_q};
                            wr_hi_q  <= 1'b0;
                        end else begin
                            wlat_q   <= wdata;
                            wr_hi_q  <= 1'b1;
                        end
                    end
                endcase
            end
            if (cnt_lat_req && clat_st_q == ACC_NONE) begin
                clat_q    <= live_cnt;
                clat_st_q <= acc_q;
            end
            if (st_lat_req && !st_vld_q) begin
                st_q     <= {live_out, 1'b0, acc_q, mode_q, bcd_q};
                st_vld_q <= 1'b1;
            end
            if (rd_stb) begin
                if (st_vld_q) begin
                    st_vld_q <= 1'b0;
                end else if (clat_st_q == ACC_WORD) begin
                    clat_st_q <= ACC_HI;
                end else if (clat_st_q != ACC_NONE) begin
                    clat_st_q <= ACC_NONE;
                end else if (acc_q == ACC_WORD) begin
                    rd_hi_q <= !rd_hi_q;
                end
            end
        end
    end

    assign ld_stb = ld_stb_q;
    assign ld_cnt = ld_cnt_q;
    assign mode   = mode_q;
    assign bcd    = bcd_q;
endmodule

// File: rtl/tmr_bus_regs.sv
// Top of the timer bus register interface: decodes bus writes, holds
// one register set per channel and muxes read data by address.
// Assumes wr_en and rd_en are never high in the same cycle.
module tmr_bus_regs
    import tmr_regs_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               addr,
    input  logic                     wr_en,
    input  logic [BYTE_W-1:0]        wdata,
    input  logic                     rd_en,
    output logic [BYTE_W-1:0]        rdata,
    input  logic [NUM_CH*CNT_W-1:0]  ch_count_i,
    input  logic [NUM_CH-1:0]        ch_out_i,
    output logic [NUM_CH-1:0]        ld_stb,
    output logic [NUM_CH*CNT_W-1:0]  ld_cnt,
    output logic [NUM_CH*MODE_W-1:0] ch_mode,
    output logic [NUM_CH-1:0]        ch_bcd
);
    logic [NUM_CH-1:0] data_wr;
    logic [NUM_CH-1:0] cfg_wr;
    logic [NUM_CH-1:0] cnt_lat_req;
    logic [NUM_CH-1:0] st_lat_req;
    logic [NUM_CH-1:0] rd_stb;
    logic [BYTE_W-1:0] rbyte_a [NUM_CH];

    tmr_cmd_decode #(.N_CH(NUM_CH)) u_dec (
        .addr        (addr),
        .wr_en       (wr_en),
        .wdata       (wdata),
        .data_wr     (data_wr),
        .cfg_wr      (cfg_wr),
        .cnt_lat_req (cnt_lat_req),
        .st_lat_req  (st_lat_req)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign rd_stb[i] = rd_en && (addr == 2'(i));
        tmr_chan_regs u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .data_wr     (data_wr[i]),
            .cfg_wr      (cfg_wr[i]),
            .cnt_lat_req (cnt_lat_req[i]),
            .st_lat_req  (st_lat_req[i]),
            .rd_stb      (rd_stb[i]),
            .wdata       (wdata),
            .live_cnt    (ch_count_i[i*CNT_W +: CNT_W]),
            .live_out    (ch_out_i[i]),
            .rbyte       (rbyte_a[i]),
            .ld_stb      (ld_stb[i]),
            .ld_cnt      (ld_cnt[i*CNT_W +: CNT_W]),
            .mode        (ch_mode[i*MODE_W +: MODE_W]),
            .bcd         (ch_bcd[i])
        );
    end

    // Read data mux; the control address reads as zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == 2'(i)) rdata = rbyte_a[i];
        end
    end
endmodule

// File: rtl/tmr_bus_regs_chk.sv
// Assertion checker for tmr_bus_regs, attached with bind below.
module tmr_bus_regs_chk
    import tmr_regs_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               addr,
    input logic                     wr_en,
    input logic [NUM_CH-1:0]        ld_stb,
    input logic [NUM_CH*CNT_W-1:0]  ld_cnt,
    input logic [NUM_CH*MODE_W-1:0] ch_mode
);
    // R4: at most one channel loads in any cycle.
    a_r4_single_load: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_stb));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // R4: a load strobe follows a write to that channel's data address.
        a_r4_load_after_write: assert property (@(posedge clk) disable iff (!rst_n)
            ld_stb[i] |-> $past(wr_en && addr == 2'(i)));
        // R3: stored modes never show the aliased codes 6 and 7.
        a_r3_mode_folded: assert property (@(posedge clk) disable iff (!rst_n)
            ch_mode[i*MODE_W +: MODE_W] <= 3'd5);
        // R5: the presented count changes only together with a load strobe.
        a_r5_count_held: assert property (@(posedge clk) disable iff (!rst_n)
            !ld_stb[i] |-> $stable(ld_cnt[i*CNT_W +: CNT_W]));
    end
endmodule

bind tmr_bus_regs tmr_bus_regs_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .ld_stb  (ld_stb),
    .ld_cnt  (ld_cnt),
    .ch_mode (ch_mode)
);

// File: tb/tb_tmr_bus_regs.sv
// Directed bench for tmr_bus_regs: one task per scenario.
module tb_tmr_bus_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic [47:0] ch_count_i = '0;
    logic [2:0]  ch_out_i = '0;
    logic [2:0]  ld_stb;
    logic [47:0] ld_cnt;
    logic [8:0]  ch_mode;
    logic [2:0]  ch_bcd;
    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    tmr_bus_regs dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .ch_count_i(ch_count_i), .ch_out_i(ch_out_i),
        .ld_stb(ld_stb), .ld_cnt(ld_cnt), .ch_mode(ch_mode), .ch_bcd(ch_bcd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 chk(req, rdata, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 strobes", ld_stb, 3'b000);
        chk("R1 counts", ld_cnt, 48'h0);
        chk("R1 modes", ch_mode, 9'h0);
        chk("R1 bcd", ch_bcd, 3'b000);
        ch_out_i[0] = 1'b1;
        wr(2'd3, 8'hE2);
        rd(2'd0, 8'hB0, "R1 R8 reset status ch0");
        ch_out_i[0] = 1'b0;
    endtask

    task automatic t_cfg();
        wr(2'd3, 8'h5D);
        chk("R3 mode 6 folds to 2", ch_mode[5:3], 3'd2);
        chk("R2 bcd ch1", ch_bcd[1], 1'b1);
        wr(2'd3, 8'hAE);
        chk("R3 mode 7 folds to 3", ch_mode[8:6], 3'd3);
        chk("R2 other channel untouched", ch_mode[2:0], 3'd0);
        wr(2'd3, 8'hEC);
        rd(2'd1, 8'h15, "R8 status ch1");
        rd(2'd2, 8'h26, "R8 status ch2");
    endtask

    task automatic t_short_write();
        wr(2'd1, 8'h5A);
        chk("R4 low-only strobe", ld_stb, 3'b010);
        chk("R4 low-only count", ld_cnt[31:16], 16'h005A);
        @(negedge clk);
        chk("R4 strobe one cycle", ld_stb, 3'b000);
        wr(2'd2, 8'h3C);
        chk("R4 high-only strobe", ld_stb, 3'b100);
        chk("R4 high-only count", ld_cnt[47:32], 16'h3C00);
    endtask

    task automatic t_word_write();
        wr(2'd3, 8'h34);
        wr(2'd0, 8'h11);
        chk("R5 first byte no load", ld_stb, 3'b000);
        wr(2'd0, 8'h22);
        chk("R5 second byte loads", ld_stb, 3'b001);
        chk("R5 word count", ld_cnt[15:0], 16'h2211);
        wr(2'd0, 8'h77);
        wr(2'd3, 8'h34);
        wr(2'd0, 8'h44);
        chk("R2 pointer reset no load", ld_stb, 3'b000);
        wr(2'd0, 8'h55);
        chk("R2 R5 count after pointer reset", ld_cnt[15:0], 16'h5544);
    endtask

    task automatic t_live_read();
        ch_count_i[15:0]  = 16'hABCD;
        ch_count_i[31:16] = 16'h6789;
        ch_count_i[47:32] = 16'h9876;
        rd(2'd0, 8'hCD, "R10 word read low");
        rd(2'd0, 8'hAB, "R10 word read high");
        rd(2'd0, 8'hCD, "R10 word read low again");
        wr(2'd3, 8'h34);
        rd(2'd0, 8'hCD, "R2 read pointer reset");
        rd(2'd1, 8'h89, "R10 low-only read");
        rd(2'd1, 8'h89, "R10 low-only repeat");
        rd(2'd2, 8'h98, "R10 high-only read");
    endtask

    task automatic t_count_latch();
        wr(2'd3, 8'h34);
        ch_count_i[15:0] = 16'hBEEF;
        wr(2'd3, 8'h00);
        ch_count_i[15:0] = 16'h1111;
        wr(2'd3, 8'h00);
        rd(2'd0, 8'hEF, "R6 latched low");
        rd(2'd0, 8'hBE, "R6 latched high, second latch ignored");
        ch_count_i[15:0] = 16'h2211;
        rd(2'd0, 8'h11, "R6 back to live low");
        rd(2'd0, 8'h22, "R6 back to live high");
        ch_count_i[15:0] = 16'h1357;
        wr(2'd3, 8'h00);
        ch_count_i[15:0] = 16'h0000;
        rd(2'd0, 8'h57, "R6 relatch low");
        rd(2'd0, 8'h13, "R6 relatch high");
        ch_count_i[31:16] = 16'h4455;
        wr(2'd3, 8'h40);
        ch_count_i[31:16] = 16'h6677;
        rd(2'd1, 8'h55, "R6 latched single byte");
        rd(2'd1, 8'h77, "R6 single byte then live");
    endtask

    task automatic t_readback();
        ch_count_i[15:0]  = 16'h4321;
        ch_out_i[0]       = 1'b1;
        ch_count_i[47:32] = 16'h9876;
        wr(2'd3, 8'hCA);
        ch_count_i[15:0]  = 16'h0000;
        ch_count_i[47:32] = 16'h5500;
        ch_out_i[0]       = 1'b0;
        rd(2'd1, 8'h77, "R7 unselected channel live");
        rd(2'd0, 8'hB4, "R9 status first ch0");
        rd(2'd0, 8'h21, "R7 latched low ch0");
        rd(2'd0, 8'h43, "R7 latched high ch0");
        rd(2'd2, 8'h26, "R9 status first ch2");
        rd(2'd2, 8'h98, "R7 latched high-only ch2");
        rd(2'd2, 8'h55, "R7 then live ch2");
    endtask

    task automatic t_status_hold();
        ch_out_i[1] = 1'b0;
        wr(2'd3, 8'hE4);
        ch_out_i[1] = 1'b1;
        wr(2'd3, 8'hE4);
        rd(2'd1, 8'h15, "R9 second status latch ignored");
        rd(2'd1, 8'h77, "R9 status returned once");
        wr(2'd3, 8'hD4);
        ch_count_i[31:16] = 16'hAAAA;
        rd(2'd1, 8'h77, "R7 count-only read-back");
        rd(2'd1, 8'hAA, "R7 count-only then live");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg();
        t_short_write();
        t_word_write();
        t_live_read();
        t_count_latch();
        t_readback();
        t_status_hold();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule